// File: doc/BRIEF.md
# HDLC Transmit Two-Half FIFO

This block buffers outgoing bytes for one HDLC transmit channel. Its storage is split into two halves of equal size. The host fills the front half one byte at a time while the write-enable flag is high. Then it pulses a commit strobe. Once the rear half has been drained by the transmitter, the whole front block moves across in a single cycle. The transmitter then pulls those bytes in the order they were written, through a valid/ready handshake.

Writing more bytes than the front half can hold raises a data-overflow flag, and the surplus bytes are thrown away. The flag stays set until the committed block moves into the rear half, or until a transmitter reset command clears the block. Framing, CRC generation and interrupt handling belong to other blocks.

Top module: `hdlc_tx_twohalf_fifo`

## Requirements
- R1: After reset, `host_wr_ok` is 1, `tx_ovf` is 0, `tx_valid` is 0 and `tx_empty` is 1.
- R2: Bytes written while `host_wr_ok` is 1 reach `tx_data` in the order they were written, across any number of commits. At most DEPTH (default 32) bytes are kept per block.
- R3: A write that arrives when the front half already holds DEPTH bytes sets `tx_ovf` on the next clock edge. The byte is discarded and the stored bytes do not change.
- R4: `tx_ovf` clears on the same edge on which the committed block moves into the rear half.
- R5: Asserting `xmit_reset` clears `tx_ovf` on the next edge.
- R6: A `host_commit` accepted while `host_wr_ok` is 1 drives `host_wr_ok` to 0 from the next cycle on. It stays 0 until the first edge on which the rear half is empty at the start of the cycle. On that edge the block transfers and `host_wr_ok` returns to 1.
- R7: Writes and commits that arrive while `host_wr_ok` is 0 have no effect: they neither store data nor set `tx_ovf`.
- R8: `tx_valid` is 1 exactly while the rear half holds unread bytes, and `tx_empty` is its inverse. A byte is consumed on each edge where both `tx_valid` and `tx_ready` are 1. While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` holds its value.
- R9: `xmit_reset` empties both halves and cancels any pending commit. From the next cycle, `host_wr_ok` is 1 and `tx_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_data | input | W | Byte written by the host |
| host_commit | input | 1 | Commit the front half for transmission |
| xmit_reset | input | 1 | Synchronous transmitter reset command |
| tx_ready | input | 1 | Transmitter takes the current byte |
| tx_valid | output | 1 | A byte is available to the transmitter |
| tx_data | output | W | Oldest unread byte of the rear half |
| tx_empty | output | 1 | Rear half fully drained |
| host_wr_ok | output | 1 | Writes to the front half are accepted |
| tx_ovf | output | 1 | More than DEPTH bytes were written to the current block |

## Verification
The assertions assume that `xmit_reset` acts on the edge where it is sampled. They also assume that `tx_ready` may change freely, with no link to `tx_valid`. Each input is driven on the falling edge, one cycle at a time, so each input is one clean value at the rising edge. The stimulus sends writes and commits while the block is locked, and resets while a commit is pending. These inputs are legal, and the model in the bench defines the expected result for them.

// File: rtl/hdlc_tx_twohalf_fifo.sv
module hdlc_tx_twohalf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_wr,
  input  logic [W-1:0] host_data,
  input  logic         host_commit,
  input  logic         xmit_reset,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  output logic         tx_empty,
  output logic         host_wr_ok,
  output logic         tx_ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  front_mem [DEPTH];
  logic [W-1:0]  rear_mem  [DEPTH];
  logic [CW-1:0] front_cnt, rear_cnt, rd_ptr;
  logic          pending;

  logic front_full, do_store, do_move, do_pop;

  assign host_wr_ok = ~pending;
  assign tx_valid   = rd_ptr < rear_cnt;
  assign tx_empty   = ~tx_valid;
  assign tx_data    = rear_mem[rd_ptr[AW-1:0]];
  assign front_full = front_cnt == CW'(DEPTH);
  assign do_store   = ~xmit_reset & ~pending & host_wr & ~front_full;
  assign do_move    = ~xmit_reset & pending & ~tx_valid;
  assign do_pop     = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front_cnt <= '0;
      rear_cnt  <= '0;
      rd_ptr    <= '0;
      pending   <= 1'b0;
      tx_ovf    <= 1'b0;
    end else if (xmit_reset) begin
      front_cnt <= '0;
      rear_cnt  <= '0;
      rd_ptr    <= '0;
      pending   <= 1'b0;
      tx_ovf    <= 1'b0;
    end else if (do_move) begin
      rear_cnt  <= front_cnt;
      rd_ptr    <= '0;
      front_cnt <= '0;
      pending   <= 1'b0;
      tx_ovf    <= 1'b0;
    end else begin
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      if (!pending) begin
        if (host_wr && front_full) tx_ovf <= 1'b1;
        if (do_store) front_cnt <= front_cnt + 1'b1;
        if (host_commit) pending <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_store) front_mem[front_cnt[AW-1:0]] <= host_data;
    if (do_move) rear_mem <= front_mem;
  end
endmodule

// File: rtl/hdlc_tx_twohalf_fifo_chk.sv
module hdlc_tx_twohalf_fifo_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_wr,
  input logic         host_commit,
  input logic         xmit_reset,
  input logic         tx_ready,
  input logic         tx_valid,
  input logic [W-1:0] tx_data,
  input logic         tx_empty,
  input logic         host_wr_ok,
  input logic         tx_ovf
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !xmit_reset |=> tx_valid && $stable(tx_data));

  p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_reset |=> host_wr_ok && tx_empty);

  p_ovf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_reset |=> !tx_ovf);

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_ok && host_commit && !xmit_reset |=> !host_wr_ok);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_ok && tx_valid && !xmit_reset |=> !host_wr_ok);

  p_ovf_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_ok && !xmit_reset |=> !tx_ovf || !host_wr_ok);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf && host_wr_ok && !xmit_reset |=> tx_ovf);

  p_locked_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_ok && !tx_ovf |=> !tx_ovf);
endmodule

bind hdlc_tx_twohalf_fifo hdlc_tx_twohalf_fifo_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_commit(host_commit),
  .xmit_reset(xmit_reset), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_empty(tx_empty), .host_wr_ok(host_wr_ok),
  .tx_ovf(tx_ovf)
);

// File: tb/test_hdlc_tx_twohalf_fifo.sv
`timescale 1ns/1ps
module test_hdlc_tx_twohalf_fifo;
  localparam int W = 8;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_commit = 1'b0, xmit_reset = 1'b0, tx_ready = 1'b0;
  logic [W-1:0] host_data = '0;
  logic tx_valid, tx_empty, host_wr_ok, tx_ovf;
  logic [W-1:0] tx_data;

  always #2.5 clk = ~clk;

  hdlc_tx_twohalf_fifo #(.W(W), .DEPTH(DEPTH)) i_hdlc_tx_twohalf_fifo (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
    .host_commit(host_commit), .xmit_reset(xmit_reset), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_empty(tx_empty),
    .host_wr_ok(host_wr_ok), .tx_ovf(tx_ovf)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [W-1:0] front_q[$], rear_q[$];
  bit m_pend = 0, m_ovf = 0;
  int seq = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(bit w, logic [W-1:0] d, bit c, bit x, bit r);
    if (x) begin
      front_q.delete(); rear_q.delete(); m_pend = 0; m_ovf = 0;
    end else if (m_pend && rear_q.size() == 0) begin
      rear_q = front_q; front_q.delete(); m_pend = 0; m_ovf = 0;
    end else begin
      if (r && rear_q.size() > 0) void'(rear_q.pop_front());
      if (!m_pend) begin
        if (w) begin
          if (front_q.size() < DEPTH) front_q.push_back(d);
          else m_ovf = 1;
        end
        if (c) m_pend = 1;
      end
    end
  endtask

  task automatic compare_all();
    chk(host_wr_ok == !m_pend, "R6 host_wr_ok", host_wr_ok, !m_pend);
    chk(tx_ovf == m_ovf, "R3 tx_ovf", tx_ovf, m_ovf);
    chk(tx_valid == (rear_q.size() > 0), "R8 tx_valid", tx_valid, rear_q.size() > 0);
    chk(tx_empty == (rear_q.size() == 0), "R8 tx_empty", tx_empty, rear_q.size() == 0);
    if (rear_q.size() > 0) chk(tx_data == rear_q[0], "R2 tx_data", tx_data, rear_q[0]);
  endtask

  task automatic step(bit w, logic [W-1:0] d, bit c, bit x, bit r);
    host_wr = w; host_data = d; host_commit = c; xmit_reset = x; tx_ready = r;
    @(posedge clk);
    model(w, d, c, x, r);
    @(negedge clk);
    compare_all();
  endtask

  task automatic write_n(int n, bit r);
    for (int i = 0; i < n; i++) begin
      step(1, W'(seq), 0, 0, r);
      seq++;
    end
  endtask

  task automatic drain(bit rnd);
    while (m_pend || rear_q.size() > 0)
      step(0, 0, 0, 0, rnd ? 1'($urandom_range(0, 1)) : 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_wr_ok == 1, "R1 wr_ok", host_wr_ok, 1);
    chk(tx_ovf == 0, "R1 ovf", tx_ovf, 0);
    chk(tx_empty == 1 && tx_valid == 0, "R1 empty", tx_empty, 1);

    write_n(5, 0);
    step(0, 0, 1, 0, 0);
    chk(host_wr_ok == 0, "R6 locked after commit", host_wr_ok, 0);
    step(0, 0, 0, 0, 0);
    chk(host_wr_ok == 1 && tx_valid == 1, "R6 released after move", host_wr_ok, 1);
    drain(0);

    write_n(32, 0);
    chk(tx_ovf == 0, "R3 no ovf at 32", tx_ovf, 0);
    step(1, 8'hEE, 0, 0, 0);
    chk(tx_ovf == 1, "R3 ovf at byte 33", tx_ovf, 1);
    step(1, 8'hEF, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(tx_ovf == 0, "R4 ovf cleared on move", tx_ovf, 0);
    chk(tx_data == W'(seq - 32), "R2 first byte kept", tx_data, W'(seq - 32));

    write_n(3, 0);
    step(0, 0, 1, 0, 1);
    step(1, 8'hAA, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk(front_q.size() == 3, "R7 locked write ignored (model)", front_q.size(), 3);
    drain(1);
    chk(tx_empty == 1, "R8 drained", tx_empty, 1);

    for (int b = 0; b < 4; b++) begin
      write_n(4 + b * 7, 1);
      step(0, 0, 1, 0, 1);
      while (m_pend) step(0, 0, 0, 0, 1'($urandom_range(0, 1)));
    end
    drain(1);

    write_n(34, 0);
    chk(tx_ovf == 1, "R3 ovf before reset", tx_ovf, 1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    chk(tx_ovf == 0, "R5 ovf cleared by reset", tx_ovf, 0);
    chk(host_wr_ok == 1 && tx_empty == 1, "R9 reset empties", host_wr_ok, 1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    chk(tx_empty == 1, "R9 front emptied by reset", tx_empty, 1);

    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 2) != 0), W'($urandom), $urandom_range(0, 15) == 0,
           $urandom_range(0, 199) == 0, 1'($urandom_range(0, 1)));
    drain(0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule